// File: doc/BRIEF.md
# Replicated Multi-Read Stack Memory

This block is a stack store for a datapath that must fetch several stack entries in one cycle. Eight read ports each take their own offset from the top of the stack. In a single cycle they return any eight entries: entries need not be neighbours, and several ports may name the same one. The contents are held in four identical dual-port RAM copies. Each copy serves two read ports, so read data leaves the RAM output registers with no selection stage after them. Usable capacity is that of one copy.

Each cycle the block accepts a push of zero, one or two entries and a pop of any count. It applies both to the entry count at once. A cycle that writes uses both ports of every copy for the write, so a read request in that cycle is refused and `wr_busy` reports this. Pops below zero and pushes past capacity saturate, and a flag reports each case.

Top module: `argstk_top`

## Requirements
- R1: After reset `stk_cnt` is 0, and `rd_valid`, `ovf_flag`, `unf_flag` and `wr_busy` are low.
- R2: `push_n` encodes 0 = none, 1 = one entry (`push_d0`), 2 or 3 = two entries. With two, `push_d0` lands below `push_d1`, so `push_d1` becomes the top. `stk_cnt` rises by the number of entries written.
- R3: Pop and push in one cycle act as pop first, then push. The new count is `stk_cnt - pop_n + pushes`, and the pushed entries start at slot `stk_cnt - pop_n`.
- R4: With `rd_req` high in a cycle that writes nothing, port k reads slot `(stk_cnt - 1 - off_k) mod DEPTH`, where `off_k` is bits `[k*AW +: AW]` of `rd_off` and offset 0 is the top. `stk_cnt` is the count before that cycle's pop or push. Data appears on `rd_data[k*DW +: DW]` one cycle later, with `rd_valid` high.
- R5: All eight ports serve arbitrary offsets in the same cycle, repeated offsets included, and ports with equal offsets return equal data.
- R6: A read issued in the cycle after a write returns the newly written data.
- R7: `wr_busy` is high in exactly the cycles that write at least one entry. A read request in such a cycle is not served, and `rd_valid` is low the next cycle.
- R8: The count never exceeds DEPTH. Pushes that do not fit are discarded, and `ovf_flag` is high in the following cycle.
- R9: A pop larger than the count leaves the count at 0 before that cycle's pushes, and `unf_flag` is high in the following cycle. Popping exactly the count does not raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_n | input | 2 | Number of entries to push |
| push_d0 | input | DW | Lower pushed entry |
| push_d1 | input | DW | Upper pushed entry |
| pop_n | input | CW | Number of entries to pop |
| rd_req | input | 1 | Read request for all eight ports |
| rd_off | input | NRD*AW | Per-port offsets from the top |
| rd_data | output | NRD*DW | Per-port read data |
| rd_valid | output | 1 | Read data valid |
| wr_busy | output | 1 | Current cycle writes; read refused |
| stk_cnt | output | CW | Entries on the stack |
| ovf_flag | output | 1 | Previous cycle dropped a push |
| unf_flag | output | 1 | Previous cycle popped past empty |

## Verification
Reads and writes compete for the same RAM ports. The bench therefore raises a read request in push cycles and in pop-only cycles. It expects refusal and `wr_busy` in the first case and service at the pre-pop count in the second. Pop and push also meet in one cycle, including a pop past empty combined with a push and a push that overflows a full stack. Each is judged against a behavioural stack model, and a scoreboard compares every served read on all eight ports.

// File: rtl/argstk_pkg.sv
package argstk_pkg;

  // Count left after popping, saturated at zero.
  function automatic int floor_sub(input int cnt, input int pop);
    return (pop > cnt) ? 0 : cnt - pop;
  endfunction

  // Decoded push request: codes 2 and 3 both mean two entries.
  function automatic int push_req(input logic [1:0] code);
    return (code == 2'd0) ? 0 : ((code == 2'd1) ? 1 : 2);
  endfunction

  // Number of requested pushes that fit above base.
  function automatic int fit_count(input int base, input int req, input int depth);
    int room;
    room = depth - base;
    return (req < room) ? req : room;
  endfunction

  // Non-negative modulo for slot indices.
  function automatic int wrap_idx(input int v, input int depth);
    int r;
    r = v % depth;
    if (r < 0) r = r + depth;
    return r;
  endfunction

endpackage

// File: rtl/argstk_ptr.sv
module argstk_ptr #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    push_n,
  input  logic [CW-1:0] pop_n,
  output logic [CW-1:0] cnt_q,
  output logic          wr0_en,
  output logic          wr1_en,
  output logic [AW-1:0] wr0_addr,
  output logic [AW-1:0] wr1_addr,
  output logic          ovf_q,
  output logic          unf_q
);
  int base_i, req_i, fit_i;
  logic [CW-1:0] cnt_d;
  logic ovf_d, unf_d;

  always_comb begin
    base_i = argstk_pkg::floor_sub(int'(cnt_q), int'(pop_n));
    req_i  = argstk_pkg::push_req(push_n);
    fit_i  = argstk_pkg::fit_count(base_i, req_i, DEPTH);
  end

  assign wr0_en   = (fit_i >= 1);
  assign wr1_en   = (fit_i >= 2);
  assign wr0_addr = AW'(argstk_pkg::wrap_idx(base_i, DEPTH));
  assign wr1_addr = AW'(argstk_pkg::wrap_idx(base_i + 1, DEPTH));
  assign cnt_d    = CW'(base_i + fit_i);
  assign ovf_d    = (req_i > fit_i);
  assign unf_d    = (int'(pop_n) > int'(cnt_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);

  assert_ovf_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> int'(cnt_q) == DEPTH);

  assert_unf_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf_q |-> int'(cnt_q) <= 2);

  assert_single_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n == 2'd1 && pop_n == '0 && int'(cnt_q) < DEPTH)
      |=> int'(cnt_q) == int'($past(cnt_q)) + 1);

endmodule

// File: rtl/argstk_raddr.sv
module argstk_raddr #(
  parameter int DEPTH = 64,
  parameter int NRD = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0]     cnt,
  input  logic [NRD*AW-1:0] offs,
  output logic [NRD*AW-1:0] addrs
);
  for (genvar k = 0; k < NRD; k++) begin : g_port
    assign addrs[k*AW +: AW] =
      AW'(argstk_pkg::wrap_idx(int'(cnt) - 1 - int'(offs[k*AW +: AW]), DEPTH));
  end
endmodule

// File: rtl/argstk_dpram.sv
module argstk_dpram #(
  parameter int DW = 16,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_q,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wd;
      else      a_q <= mem[a_addr];
    end
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wd;
      else      b_q <= mem[b_addr];
    end
  end

  assert_distinct_writes_R2: assert property (@(posedge clk)
    (a_en && a_we && b_en && b_we) |-> a_addr != b_addr);

endmodule

// File: rtl/argstk_top.sv
module argstk_top #(
  parameter int DW = 16,
  parameter int DEPTH = 64,
  parameter int NRD = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int NCOPY = NRD / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        push_n,
  input  logic [DW-1:0]     push_d0,
  input  logic [DW-1:0]     push_d1,
  input  logic [CW-1:0]     pop_n,
  input  logic              rd_req,
  input  logic [NRD*AW-1:0] rd_off,
  output logic [NRD*DW-1:0] rd_data,
  output logic              rd_valid,
  output logic              wr_busy,
  output logic [CW-1:0]     stk_cnt,
  output logic              ovf_flag,
  output logic              unf_flag
);
  logic          wr0_en, wr1_en;
  logic [AW-1:0] wr0_addr, wr1_addr;
  logic [NRD*AW-1:0] raddr;
  logic          rd_go;
  logic          rd_valid_q;

  argstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .pop_n(pop_n),
    .cnt_q(stk_cnt), .wr0_en(wr0_en), .wr1_en(wr1_en),
    .wr0_addr(wr0_addr), .wr1_addr(wr1_addr),
    .ovf_q(ovf_flag), .unf_q(unf_flag)
  );

  argstk_raddr #(.DEPTH(DEPTH), .NRD(NRD)) u_raddr (
    .cnt(stk_cnt), .offs(rd_off), .addrs(raddr)
  );

  // Writes own every RAM port in a write cycle; reads wait.
  assign wr_busy = wr0_en;
  assign rd_go   = rd_req && !wr_busy;

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    logic [DW-1:0] qa, qb;
    argstk_dpram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk(clk),
      .a_en(wr0_en || rd_go), .a_we(wr0_en),
      .a_addr(wr0_en ? wr0_addr : raddr[(2*c)*AW +: AW]),
      .a_wd(push_d0), .a_q(qa),
      .b_en(wr1_en || rd_go), .b_we(wr1_en),
      .b_addr(wr_busy ? wr1_addr : raddr[(2*c+1)*AW +: AW]),
      .b_wd(push_d1), .b_q(qb)
    );
    assign rd_data[(2*c)*DW +: DW]   = qa;
    assign rd_data[(2*c+1)*DW +: DW] = qb;

    assert_copy_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_q && $past(raddr[(2*c)*AW +: AW] == raddr[0 +: AW]))
        |-> qa == g_copy[0].qa);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_valid_q <= 1'b0;
    else        rd_valid_q <= rd_go;
  end
  assign rd_valid = rd_valid_q;

  assert_busy_blocks_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |=> !rd_valid);

  assert_read_served_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !wr_busy) |=> rd_valid);

endmodule

// File: tb/sim_argstk_top.sv
`timescale 1ns/1ps
module sim_argstk_top;
  localparam int DW = 16;
  localparam int DEPTH = 64;
  localparam int NRD = 8;
  localparam int AW = 6;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] push_n = '0;
  logic [DW-1:0] push_d0 = '0, push_d1 = '0;
  logic [CW-1:0] pop_n = '0;
  logic rd_req = 1'b0;
  logic [NRD*AW-1:0] rd_off = '0;
  logic [NRD*DW-1:0] rd_data;
  logic rd_valid, wr_busy, ovf_flag, unf_flag;
  logic [CW-1:0] stk_cnt;

  always #5 clk = ~clk;

  argstk_top u0 (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_d0(push_d0),
    .push_d1(push_d1), .pop_n(pop_n), .rd_req(rd_req), .rd_off(rd_off),
    .rd_data(rd_data), .rd_valid(rd_valid), .wr_busy(wr_busy),
    .stk_cnt(stk_cnt), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] model [DEPTH];
  int mcnt = 0;
  int offs [NRD];
  logic [NRD*DW-1:0] expq [$];
  string tagq [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare every served read against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R4", "unexpected rd_valid", 1, 0);
      end else begin
        logic [NRD*DW-1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        for (int k = 0; k < NRD; k++)
          check(rd_data[k*DW +: DW] == e[k*DW +: DW], t,
                $sformatf("port %0d data", k),
                rd_data[k*DW +: DW], e[k*DW +: DW]);
      end
    end
  end

  // Driver: one cycle of stimulus, model update and registered-output checks.
  task automatic cyc(input int pc, input logic [DW-1:0] d0, input logic [DW-1:0] d1,
                     input int pop, input bit rq, input string tag);
    int base, req, fit;
    bit ebusy, eovf, eunf;
    logic [NRD*DW-1:0] e;
    @(negedge clk);
    push_n = 2'(pc); push_d0 = d0; push_d1 = d1; pop_n = CW'(pop); rd_req = rq;
    for (int k = 0; k < NRD; k++) rd_off[k*AW +: AW] = AW'(offs[k]);
    base  = (pop > mcnt) ? 0 : mcnt - pop;
    req   = (pc == 0) ? 0 : ((pc == 1) ? 1 : 2);
    fit   = (req < DEPTH - base) ? req : DEPTH - base;
    ebusy = (fit > 0);
    eovf  = (req > fit);
    eunf  = (pop > mcnt);
    #1;
    check(wr_busy == ebusy, "R7", "wr_busy", wr_busy, ebusy);
    if (rq && !ebusy) begin
      for (int k = 0; k < NRD; k++)
        e[k*DW +: DW] = model[((mcnt - 1 - offs[k]) % DEPTH + DEPTH) % DEPTH];
      expq.push_back(e);
      tagq.push_back(tag);
    end
    if (fit >= 1) model[base] = d0;
    if (fit >= 2) model[base + 1] = d1;
    mcnt = base + fit;
    @(posedge clk);
    #1;
    check(int'(stk_cnt) == mcnt, tag, "stk_cnt", stk_cnt, mcnt);
    check(ovf_flag == eovf, "R8", "ovf_flag", ovf_flag, eovf);
    check(unf_flag == eunf, "R9", "unf_flag", unf_flag, eunf);
    check(rd_valid == (rq && !ebusy), "R7", "rd_valid", rd_valid, rq && !ebusy);
    push_n = '0; pop_n = '0; rd_req = 1'b0;
  endtask

  task automatic set_offs(input int o0, input int o1, input int o2, input int o3,
                          input int o4, input int o5, input int o6, input int o7);
    offs[0] = o0; offs[1] = o1; offs[2] = o2; offs[3] = o3;
    offs[4] = o4; offs[5] = o5; offs[6] = o6; offs[7] = o7;
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "R1", "watchdog expired", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    set_offs(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(stk_cnt == 0, "R1", "stk_cnt", stk_cnt, 0);
    check(rd_valid == 0, "R1", "rd_valid", rd_valid, 0);
    check(ovf_flag == 0 && unf_flag == 0, "R1", "flags", {ovf_flag, unf_flag}, 0);
    check(wr_busy == 0, "R1", "wr_busy", wr_busy, 0);

    // R2: single and double pushes, code 3 as two
    for (int i = 0; i < 5; i++) cyc(1, 16'h1000 + 16'(i), 16'h0, 0, 0, "R2");
    cyc(2, 16'h2000, 16'h2001, 0, 0, "R2");
    cyc(2, 16'h2010, 16'h2011, 0, 0, "R2");
    cyc(3, 16'h2020, 16'h2021, 0, 0, "R2");

    // R4: read the top eight
    set_offs(0, 1, 2, 3, 4, 5, 6, 7);
    cyc(0, 0, 0, 0, 1, "R4");
    // R5: scattered and repeated offsets
    set_offs(3, 3, 0, 10, 1, 7, 7, 2);
    cyc(0, 0, 0, 0, 1, "R5");
    set_offs(10, 9, 8, 10, 0, 0, 4, 6);
    cyc(0, 0, 0, 0, 1, "R5");

    // R7: read requested while pushing is refused
    cyc(2, 16'h3000, 16'h3001, 0, 1, "R7");
    // R6: read right after the write
    set_offs(0, 1, 2, 0, 1, 2, 3, 1);
    cyc(0, 0, 0, 0, 1, "R6");

    // R4: read in a pop-only cycle uses the pre-pop count
    set_offs(0, 1, 2, 3, 4, 5, 6, 7);
    cyc(0, 0, 0, 2, 1, "R4");
    // R3: pop and push together
    cyc(2, 16'h4000, 16'h4001, 3, 0, "R3");
    cyc(1, 16'h4100, 16'h0, 1, 0, "R3");
    cyc(0, 0, 0, 0, 1, "R3");

    // R8: fill to capacity, then overflow
    while (mcnt < DEPTH - 1) cyc(1, 16'h5000 + 16'(mcnt), 16'h0, 0, 0, "R8");
    cyc(2, 16'h5A5A, 16'h5B5B, 0, 1, "R8");
    set_offs(0, 63, 1, 62, 5, 5, 30, 31);
    cyc(1, 16'h5C5C, 16'h0, 0, 1, "R8");
    cyc(0, 0, 0, 0, 1, "R8");

    // R9: pop past empty combined with a push, wrapped reads
    cyc(1, 16'hBEEF, 16'h0, 100, 0, "R9");
    set_offs(0, 1, 2, 40, 63, 0, 5, 1);
    cyc(0, 0, 0, 0, 1, "R9");
    cyc(0, 0, 0, 1, 0, "R9");
    cyc(0, 0, 0, 0, 0, "R9");

    @(negedge clk);
    @(negedge clk);
    check(expq.size() == 0, "R4", "reads left unserved", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule